// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 12-bit successive-approximation conversion against an external DAC and comparator. A low-to-high transition on the convert command starts a gated conversion clock. The clock is derived from the system clock, and each of its periods lasts two system cycles. The block drives a trial code to the DAC for each bit, from the most significant bit down to the least significant. On each falling edge of the gated clock it reads the one-bit comparator answer and keeps or drops the bit under test. While the conversion runs, a busy flag is high. Each bit leaves on an NRZ serial line, most significant first, as soon as it is decided. The parallel result builds up bit by bit in one of three code formats.

The controller is a four-state machine:
- **IDLE**: the gated clock rests high. A rising command takes the **start** transition to SETUP. That edge is the first falling edge, which raises busy and clears the outputs.
- **SETUP**: covers the first gated-clock period. The second falling edge takes the **arm** transition to CONV and presents the MSB trial.
- **CONV**: one bit is decided on every later falling edge. The falling edge that decides the LSB takes the **last-bit** transition to STOP.
- **STOP**: returns the gated clock high and drops busy. The **return** transition leads back to IDLE.

Top module: `sar_seq`

## Requirements
- R1: After a synchronous active-high reset, busy is 0, the gated clock is 1, and the parallel output, serial output and trial code are all 0.
- R2: A 0-to-1 change of the convert command, seen in IDLE, starts a conversion. From the next system edge, busy is 1, the gated clock is 0, the parallel output is 0 and the serial output is 0.
- R3: While busy, the gated clock toggles on every system clock edge. Busy stays high for exactly 27 system cycles, which covers 14 falling edges of the gated clock.
- R4: From the second falling edge, the trial code has the bit under test set to 1 and all decided bits at their decided values. All lower bits are 0. The first trial is 0x800. A bit stays 1 only when the comparator input is 1, meaning the input is at or above the trial level.
- R5: With an ideal comparator, the decided code equals the input level code.
- R6: The serial output is NRZ and sends the MSB first. Bit 11 down to bit 0 are valid at the 3rd through the 14th rising edges of the gated clock. The serial value never changes on a rising edge.
- R7: After the LSB decision, the gated clock returns to 1 and stays there, and busy returns to 0.
- R8: A command still high when busy falls starts no further conversion. A new conversion needs a fresh 0-to-1 change.
- R9: A command pulse one system cycle long gives exactly one conversion. So does a command held for several gated-clock edges.
- R10: The format select sets the parallel coding: 0 is straight binary, 1 is offset binary (the same bits), 2 is two's complement (bit 11 inverted), and 3 is straight binary. The serial stream always carries the uninverted bits.
- R11: Whenever busy is 0, the trial code is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_cmd | input | 1 | Convert command; a rising change starts a conversion |
| cmp_ge | input | 1 | Comparator answer: 1 when the input is at or above the trial level |
| fmt_sel | input | 2 | Parallel code format select |
| busy | output | 1 | High while a conversion runs |
| gclk | output | 1 | Gated conversion clock; rests at 1 |
| trial | output | N | Trial code driven to the DAC |
| par_out | output | N | Parallel result in the selected format |
| ser_out | output | 1 | NRZ serial result, MSB first |

## Verification
The bench builds the block with its default width of 12, which makes the 27-cycle busy window and the 14-edge gated-clock sequence exact, countable quantities. At that width, input codes at zero, full scale and either side of mid-scale each fit into one run of a few dozen cycles. This makes every code format and both ends of the trial search easy to exercise, along with a command that is held past the end of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    // controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_CONV  = 2'd2,
        ST_STOP  = 2'd3
    } seq_state_e;

    // parallel output code formats
    typedef enum logic [1:0] {
        FMT_BIN  = 2'd0,
        FMT_OFS  = 2'd1,
        FMT_TWOS = 2'd2,
        FMT_RSV  = 2'd3
    } code_fmt_e;

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_cmd,
    output logic          gclk,
    output logic          busy,
    output logic          start,
    output logic          dec,
    output logic          active,
    output logic [IW-1:0] bit_idx
);

    localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

    seq_state_e state_q, state_d;
    logic       cmd_q;

    // transition decode
    always_comb begin
        start   = (state_q == ST_IDLE) && conv_cmd && !cmd_q;
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                      state_d = ST_SETUP;
            ST_SETUP: if (gclk)                       state_d = ST_CONV;
            ST_CONV:  if (gclk && bit_idx == '0)      state_d = ST_STOP;
            ST_STOP:                                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // combinational status outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        active = (state_q == ST_CONV);
        dec    = (state_q == ST_CONV) && gclk;
    end

    // registered outputs: gated clock, bit pointer, command history
    always_ff @(posedge clk) begin
        if (rst) begin
            gclk    <= 1'b1;
            bit_idx <= '0;
            cmd_q   <= 1'b0;
        end else begin
            cmd_q <= conv_cmd;
            unique case (state_q)
                ST_IDLE: gclk <= !start;
                ST_SETUP: begin
                    gclk <= !gclk;
                    if (gclk) bit_idx <= TOP_IDX;
                end
                ST_CONV: begin
                    gclk <= !gclk;
                    if (gclk && bit_idx != '0) bit_idx <= bit_idx - 1'b1;
                end
                ST_STOP: gclk <= 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath #(
    parameter int N  = 12,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          dec,
    input  logic          active,
    input  logic [IW-1:0] bit_idx,
    input  logic          cmp_ge,
    output logic [N-1:0]  trial,
    output logic [N-1:0]  res_nxt,
    output logic          ser_out
);

    logic [N-1:0] res_q;
    logic [N-1:0] probe;

    always_comb begin
        probe   = N'(1) << bit_idx;
        res_nxt = cmp_ge ? (res_q | probe) : (res_q & ~probe);
        trial   = active ? (res_q | probe) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || start) begin
            res_q   <= '0;
            ser_out <= 1'b0;
        end else if (dec) begin
            res_q   <= res_nxt;
            ser_out <= cmp_ge;
        end
    end

endmodule

// File: rtl/sar_seq_fmt.sv
module sar_seq_fmt
    import sar_seq_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         dec,
    input  logic [1:0]   fmt_sel,
    input  logic [N-1:0] res_nxt,
    output logic [N-1:0] par_out
);

    localparam logic [N-1:0] SIGN_MASK = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] shaped;

    always_comb begin
        unique case (code_fmt_e'(fmt_sel))
            FMT_TWOS: shaped = res_nxt ^ SIGN_MASK;
            FMT_OFS:  shaped = res_nxt;
            FMT_BIN:  shaped = res_nxt;
            FMT_RSV:  shaped = res_nxt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || start) par_out <= '0;
        else if (dec)     par_out <= shaped;
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         conv_cmd,
    input  logic         cmp_ge,
    input  logic [1:0]   fmt_sel,
    output logic         busy,
    output logic         gclk,
    output logic [N-1:0] trial,
    output logic [N-1:0] par_out,
    output logic         ser_out
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic          start, dec, active;
    logic [IW-1:0] bit_idx;
    logic [N-1:0]  res_nxt;

    sar_seq_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk(clk), .rst(rst), .conv_cmd(conv_cmd),
        .gclk(gclk), .busy(busy), .start(start), .dec(dec),
        .active(active), .bit_idx(bit_idx)
    );

    sar_seq_dpath #(.N(N), .IW(IW)) u_dpath (
        .clk(clk), .rst(rst), .start(start), .dec(dec), .active(active),
        .bit_idx(bit_idx), .cmp_ge(cmp_ge), .trial(trial),
        .res_nxt(res_nxt), .ser_out(ser_out)
    );

    sar_seq_fmt #(.N(N)) u_fmt (
        .clk(clk), .rst(rst), .start(start), .dec(dec),
        .fmt_sel(fmt_sel), .res_nxt(res_nxt), .par_out(par_out)
    );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int N = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         busy,
    input logic         gclk,
    input logic [N-1:0] trial,
    input logic [N-1:0] par_out,
    input logic         ser_out
);

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!gclk && par_out == '0 && !ser_out));

    // R3
    gclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (gclk != $past(gclk)));

    // R7
    idle_clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> gclk);

    // R11
    idle_trial_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (trial == '0));

    // R6
    ser_hold_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(gclk) |-> $stable(ser_out));

endmodule

bind sar_seq sar_seq_chk #(.N(N)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .gclk(gclk),
    .trial(trial), .par_out(par_out), .ser_out(ser_out)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;

    localparam int N = 12;
    localparam logic [N-1:0] MSB = {1'b1, {(N-1){1'b0}}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         conv_cmd = 1'b0;
    logic [1:0]   fmt_sel = 2'd0;
    logic [N-1:0] vin = '0;
    logic         cmp_ge;
    logic         busy, gclk, ser_out;
    logic [N-1:0] trial, par_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic         exp_bits[$];
    logic [N-1:0] exp_par[$];
    logic [N-1:0] exp_trial2[$];

    always #10 clk = ~clk;

    // ideal comparator model
    assign cmp_ge = (vin >= trial);

    sar_seq #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .conv_cmd(conv_cmd), .cmp_ge(cmp_ge),
        .fmt_sel(fmt_sel), .busy(busy), .gclk(gclk), .trial(trial),
        .par_out(par_out), .ser_out(ser_out)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: pushes expectations, then runs one conversion
    task automatic run_conv(input logic [N-1:0] v, input logic [1:0] f, input int hold);
        int  ncyc;
        bit  seen;
        vin     = v;
        fmt_sel = f;
        for (int b = N - 1; b >= 0; b--) exp_bits.push_back(v[b]);
        exp_par.push_back((f == 2'd2) ? (v ^ MSB) : v);
        exp_trial2.push_back((v & MSB) | (MSB >> 1));
        @(negedge clk);
        conv_cmd = 1'b1;
        ncyc = 0;
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i == 0)  // R2 first falling edge clears outputs
                check(busy && !gclk && par_out == '0 && !ser_out, "R2 start state",
                      {busy, gclk, ser_out, 17'd0, par_out}, {1'b1, 1'b0, 1'b0, 29'd0});
            if (i + 1 >= hold) conv_cmd = 1'b0;
            if (busy) begin
                ncyc++;
                seen = 1'b1;
            end else if (seen && i + 1 >= hold) begin
                break;
            end
        end
        // R3 R8 R9 one conversion of 27 cycles
        check(ncyc == 27, "R3 R8 R9 busy length", ncyc, 27);
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            // R7 idle after conversion
            check(!busy && gclk, "R7 idle clock high", {busy, gclk}, 2'b01);
        end
        // R11 trial quiet when idle
        check(trial == '0, "R11 idle trial", trial, 0);
    endtask

    // monitor: pops and compares as the design produces results
    initial begin
        forever begin
            @(posedge busy);
            for (int k = 1; k <= 14; k++) begin
                @(posedge gclk);
                #2;
                if (k == 2) check(trial == MSB, "R4 first trial", trial, MSB);
                if (k == 3 && exp_trial2.size() > 0) begin
                    logic [N-1:0] t2;
                    t2 = exp_trial2.pop_front();
                    check(trial == t2, "R4 second trial", trial, t2);
                end
                if (k >= 3 && exp_bits.size() > 0) begin
                    logic eb;
                    eb = exp_bits.pop_front();
                    check(ser_out == eb, "R6 R10 serial bit", ser_out, eb);
                end
            end
            @(negedge clk);
            if (exp_par.size() > 0) begin
                logic [N-1:0] ep;
                ep = exp_par.pop_front();
                check(par_out == ep, "R5 R10 parallel result", par_out, ep);
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && gclk && par_out == '0 && !ser_out && trial == '0, "R1 reset state",
              {busy, gclk, ser_out, 5'd0, par_out, trial}, {1'b0, 1'b1, 30'd0});

        run_conv(12'hA5C, 2'd0, 1);   // R5 R9 short pulse, binary
        run_conv(12'h000, 2'd0, 1);   // R4 all bits rejected
        run_conv(12'hFFF, 2'd1, 8);   // R9 held command, offset binary
        run_conv(12'h800, 2'd2, 3);   // R10 two's complement at mid-scale
        run_conv(12'h7FF, 2'd2, 1);   // R10 two's complement just below
        run_conv(12'h3C1, 2'd3, 1);   // R10 code 3 behaves as binary
        run_conv(12'h5A5, 2'd0, 40);  // R8 command held past the end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule